// File: doc/BRIEF.md
# Multi-Queue Transmit Frame Scheduler

This block picks which of eight transmit queues sends the next frame. Each queue reports whether it is switched on, whether it holds a frame, how long its head frame is in bytes, and an 8-bit weight. The scheduler issues a one-cycle grant with the chosen queue index. It then waits for a completion pulse before it makes another choice, so one frame is in flight at a time and every frame is atomic.

There are two policies. Any mode value other than binary 10 selects strict priority, in which the lowest-numbered eligible queue wins and the choice is made again at every frame boundary. Mode 10 selects credit-weighted round-robin. Queues 1 to 7 take turns in ascending order and wrap back to 1. Before every one of those slots, queue 0 receives an expedited turn. On a turn, a queue adds its weight to a signed credit counted in 64-byte units. It sends frames while the credit is above zero, and each frame deducts its length, rounded up to whole units. The credit may go negative.

Top module: `txq_credit_sched`

## Requirements
- R1: After reset `grant_o` is low and `sel_q_o` is 0, and no grant is issued while no queue is both enabled and non-empty.
- R2: With `mode_i` not equal to 2'b10, each grant goes to the lowest-indexed queue that is enabled and non-empty at the decision, and the choice is re-made after every frame.
- R3: `grant_o` is high for one cycle per frame. After it, `sel_q_o` holds and no grant follows until `frame_done_i` is seen. In priority mode the next grant appears two cycles after the cycle in which `frame_done_i` is high.
- R4: In mode 2'b10, a queue's turn adds its weight to its credit. Grants continue while the credit is above zero, and each grant subtracts ceil(length/64).
- R5: In mode 2'b10, turns for queues 1..7 go in ascending order and wrap from 7 to 1. A slot whose queue is disabled or empty is skipped.
- R6: In mode 2'b10, queue 0 (if enabled and non-empty) takes a full credit turn before every slot of queues 1..7, including skipped slots.
- R7: If the queue that holds the turn is found empty or disabled at a decision, its credit becomes zero and its turn ends.
- R8: A cycle with `clr_credits_i` high zeroes every credit, restarts the rotation with queue 0's turn ahead of queue 1, and issues no grant. This also holds when it coincides with `frame_done_i`.
- R9: A change of `mode_i` is applied only when no frame is outstanding. Applying it clears credits and turn state the same way R8 does.
- R10: A disabled queue is never granted in either mode, even when it holds frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Policy: 2'b10 weighted, anything else strict priority |
| clr_credits_i | input | 1 | Clear all credits and restart the rotation |
| q_en_i | input | 8 | Per-queue enable |
| q_ready_i | input | 8 | Per-queue non-empty flag |
| head_len_i | input | 128 | Head-frame byte length, 16 bits per queue, queue 0 in the low bits |
| weight_i | input | 64 | Per-queue weight in 64-byte units, 8 bits per queue, queue 0 in the low bits |
| frame_done_i | input | 1 | Pulse: the granted frame has been sent |
| grant_o | output | 1 | One-cycle grant strobe |
| sel_q_o | output | 3 | Granted queue index, held until the next grant |

## Verification
Two events can land in the same cycle: completion of an in-flight frame and a credit clear (or a mode change that has been pending since before completion). The bench raises `clr_credits_i` in exactly the cycle that carries `frame_done_i`, after a queue has been left with leftover positive credit. It then compares the following grant order with a fresh rotation: a full weight's worth of frames for queue 1 before queue 2. A surviving residue would cut queue 1's share short. A mode switch made while a frame is outstanding is checked the same way. The bench confirms that no grant appears and the selection holds until completion, and that the next weighted rotation starts from cleared credits.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

   localparam logic [1:0] MODE_WEIGHTED = 2'b10;

   typedef enum logic {
      ST_EVAL,
      ST_WAIT
   } sched_st_e;

   typedef enum logic [2:0] {
      ACT_GRANT,
      ACT_END,
      ACT_DRAIN,
      ACT_START0,
      ACT_MARK0,
      ACT_START_RR,
      ACT_SKIP_RR
   } wrr_act_e;

endpackage

// File: rtl/txq_len_units.sv
module txq_len_units #(
   parameter int LEN_W     = 16,
   parameter int UNIT_LOG2 = 6,
   parameter bit ROUND_UP  = 1'b1,
   localparam int U_W      = LEN_W - UNIT_LOG2 + 1
) (
   input  logic [LEN_W-1:0] len_i,
   output logic [U_W-1:0]   units_o
);

   if (UNIT_LOG2 < 1 || UNIT_LOG2 >= LEN_W) begin : g_bad_unit
      $error("txq_len_units: UNIT_LOG2 out of range");
   end

   if (ROUND_UP) begin : g_ceil
      localparam logic [LEN_W:0] ADD = (LEN_W+1)'((2 ** UNIT_LOG2) - 1);
      logic [LEN_W:0] sum;
      assign sum     = {1'b0, len_i} + ADD;
      assign units_o = sum[LEN_W:UNIT_LOG2];
   end else begin : g_floor
      assign units_o = {1'b0, len_i[LEN_W-1:UNIT_LOG2]};
   end

endmodule

// File: rtl/txq_prio_pick.sv
module txq_prio_pick #(
   parameter int NQ = 8,
   localparam int QW = $clog2(NQ)
) (
   input  logic [NQ-1:0] req_i,
   output logic          pick_v_o,
   output logic [QW-1:0] pick_q_o
);

   if (NQ < 2) begin : g_bad_nq
      $error("txq_prio_pick: NQ must be at least 2");
   end

   always_comb begin
      pick_v_o = 1'b0;
      pick_q_o = '0;
      for (int i = NQ - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            pick_v_o = 1'b1;
            pick_q_o = QW'(i);
         end
      end
   end

endmodule

// File: rtl/txq_wrr_core.sv
module txq_wrr_core
   import txq_sched_pkg::*;
#(
   parameter int NQ   = 8,
   parameter int WT_W = 8,
   parameter int U_W  = 11,
   parameter int CR_W = 16,
   localparam int QW  = $clog2(NQ)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step_i,
   input  logic                     flush_i,
   input  logic [NQ-1:0]            elig_i,
   input  logic [NQ-1:0][WT_W-1:0]  weight_i,
   input  logic [NQ-1:0][U_W-1:0]   units_i,
   output logic                     gnt_v_o,
   output logic [QW-1:0]            gnt_q_o
);

   if (CR_W < U_W + 2 || CR_W < WT_W + 2) begin : g_bad_cr
      $error("txq_wrr_core: CR_W too narrow for weight or overdraw");
   end

   logic [NQ-1:0][CR_W-1:0] cr_q;
   logic                    in_turn_q;
   logic                    zero_done_q;
   logic [QW-1:0]           cur_q;
   logic [QW-1:0]           rr_q;
   logic [QW-1:0]           rr_nxt;
   logic signed [CR_W-1:0]  cur_cr;
   wrr_act_e                act;

   assign cur_cr = $signed(cr_q[cur_q]);
   assign rr_nxt = (rr_q == QW'(NQ - 1)) ? QW'(1) : rr_q + QW'(1);

   always_comb begin
      if (in_turn_q) begin
         if (!elig_i[cur_q])   act = ACT_DRAIN;
         else if (cur_cr > 0)  act = ACT_GRANT;
         else                  act = ACT_END;
      end else if (!zero_done_q) begin
         act = elig_i[0] ? ACT_START0 : ACT_MARK0;
      end else begin
         act = elig_i[rr_q] ? ACT_START_RR : ACT_SKIP_RR;
      end
   end

   assign gnt_v_o = step_i && !flush_i && (act == ACT_GRANT);
   assign gnt_q_o = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr_q        <= '0;
         in_turn_q   <= 1'b0;
         zero_done_q <= 1'b0;
         cur_q       <= '0;
         rr_q        <= QW'(1);
      end else if (flush_i) begin
         cr_q        <= '0;
         in_turn_q   <= 1'b0;
         zero_done_q <= 1'b0;
         cur_q       <= '0;
         rr_q        <= QW'(1);
      end else if (step_i) begin
         case (act)
            ACT_GRANT: begin
               cr_q[cur_q] <= cr_q[cur_q] - CR_W'(units_i[cur_q]);
            end
            ACT_END: begin
               in_turn_q <= 1'b0;
            end
            ACT_DRAIN: begin
               cr_q[cur_q] <= '0;
               in_turn_q   <= 1'b0;
            end
            ACT_START0: begin
               cr_q[0]     <= cr_q[0] + CR_W'(weight_i[0]);
               cur_q       <= '0;
               in_turn_q   <= 1'b1;
               zero_done_q <= 1'b1;
            end
            ACT_MARK0: begin
               zero_done_q <= 1'b1;
            end
            ACT_START_RR: begin
               cr_q[rr_q]  <= cr_q[rr_q] + CR_W'(weight_i[rr_q]);
               cur_q       <= rr_q;
               in_turn_q   <= 1'b1;
               rr_q        <= rr_nxt;
               zero_done_q <= 1'b0;
            end
            default: begin
               rr_q        <= rr_nxt;
               zero_done_q <= 1'b0;
            end
         endcase
      end
   end

   assert_drain_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !flush_i && in_turn_q && !elig_i[cur_q])
      |=> (cr_q[$past(cur_q)] == '0 && !in_turn_q));

   assert_rr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rr_q != '0) && (rr_q <= QW'(NQ - 1)));

   assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (cr_q == '0 && !in_turn_q && rr_q == QW'(1)));

   assert_grant_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_v_o |-> ($signed(cr_q[gnt_q_o]) > 0 && elig_i[gnt_q_o]));

endmodule

// File: rtl/txq_credit_sched.sv
module txq_credit_sched
   import txq_sched_pkg::*;
#(
   parameter int NQ        = 8,
   parameter int LEN_W     = 16,
   parameter int WT_W      = 8,
   parameter int UNIT_LOG2 = 6,
   parameter int CR_W      = 16,
   parameter bit ROUND_UP  = 1'b1,
   localparam int QW       = $clog2(NQ),
   localparam int U_W      = LEN_W - UNIT_LOG2 + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            mode_i,
   input  logic                  clr_credits_i,
   input  logic [NQ-1:0]         q_en_i,
   input  logic [NQ-1:0]         q_ready_i,
   input  logic [NQ*LEN_W-1:0]   head_len_i,
   input  logic [NQ*WT_W-1:0]    weight_i,
   input  logic                  frame_done_i,
   output logic                  grant_o,
   output logic [QW-1:0]         sel_q_o
);

   if (NQ < 2 || (2 ** QW) != NQ) begin : g_bad_nq
      $error("txq_credit_sched: NQ must be a power of two >= 2");
   end

   sched_st_e                st_q;
   logic [1:0]               mode_q;
   logic [NQ-1:0]            elig;
   logic [NQ-1:0][U_W-1:0]   units;
   logic [NQ-1:0][WT_W-1:0]  wts;
   logic                     at_eval;
   logic                     mode_chg;
   logic                     flush;
   logic                     wrr_step;
   logic                     pick_v;
   logic [QW-1:0]            pick_q;
   logic                     wrr_v;
   logic [QW-1:0]            wrr_q;
   logic                     dec_v;
   logic [QW-1:0]            dec_q;

   assign elig = q_en_i & q_ready_i;

   for (genvar g = 0; g < NQ; g++) begin : g_queue
      assign wts[g] = weight_i[g*WT_W +: WT_W];
      txq_len_units #(
         .LEN_W     (LEN_W),
         .UNIT_LOG2 (UNIT_LOG2),
         .ROUND_UP  (ROUND_UP)
      ) u_units (
         .len_i   (head_len_i[g*LEN_W +: LEN_W]),
         .units_o (units[g])
      );
   end

   assign at_eval  = (st_q == ST_EVAL);
   assign mode_chg = at_eval && (mode_i != mode_q);
   assign flush    = clr_credits_i || mode_chg;
   assign wrr_step = at_eval && !mode_chg && (mode_q == MODE_WEIGHTED);

   txq_prio_pick #(.NQ(NQ)) u_pick (
      .req_i    (elig),
      .pick_v_o (pick_v),
      .pick_q_o (pick_q)
   );

   txq_wrr_core #(
      .NQ   (NQ),
      .WT_W (WT_W),
      .U_W  (U_W),
      .CR_W (CR_W)
   ) u_wrr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (wrr_step),
      .flush_i  (flush),
      .elig_i   (elig),
      .weight_i (wts),
      .units_i  (units),
      .gnt_v_o  (wrr_v),
      .gnt_q_o  (wrr_q)
   );

   always_comb begin
      if (mode_q == MODE_WEIGHTED) begin
         dec_v = wrr_v;
         dec_q = wrr_q;
      end else begin
         dec_v = at_eval && !flush && pick_v;
         dec_q = pick_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_EVAL;
         mode_q  <= 2'b00;
         grant_o <= 1'b0;
         sel_q_o <= '0;
      end else begin
         grant_o <= 1'b0;
         if (mode_chg) mode_q <= mode_i;
         case (st_q)
            ST_EVAL: begin
               if (dec_v) begin
                  grant_o <= 1'b1;
                  sel_q_o <= dec_q;
                  st_q    <= ST_WAIT;
               end
            end
            default: begin
               if (frame_done_i) st_q <= ST_EVAL;
            end
         endcase
      end
   end

   assert_grant_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |=> !grant_o);

   assert_hold_in_flight_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && !frame_done_i) |=> (!grant_o && $stable(sel_q_o)));

   assert_prio_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (at_eval && mode_q != MODE_WEIGHTED && pick_v)
      |-> (elig[pick_q] && ((elig & ((NQ'(1) << pick_q) - NQ'(1))) == '0)));

   assert_grant_eligible_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (at_eval && dec_v) |-> elig[dec_q]);

   assert_mode_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |=> $stable(mode_q));

endmodule

// File: tb/tb_txq_credit_sched.sv
module tb_txq_credit_sched;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode = 2'b00;
   logic              clr = 1'b0;
   logic [7:0]        en = '0;
   logic [7:0]        rdy = '0;
   logic [7:0][15:0]  lens = '0;
   logic [7:0][7:0]   wts = '0;
   logic              fd = 1'b0;
   logic              grant_o;
   logic [2:0]        sel_q_o;

   int frm [8];
   int exp_q [16];
   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   txq_credit_sched dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_i        (mode),
      .clr_credits_i (clr),
      .q_en_i        (en),
      .q_ready_i     (rdy),
      .head_len_i    (lens),
      .weight_i      (wts),
      .frame_done_i  (fd),
      .grant_o       (grant_o),
      .sel_q_o       (sel_q_o)
   );

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic refresh();
      for (int i = 0; i < 8; i++) rdy[i] = (frm[i] > 0);
   endtask

   task automatic idle_all();
      for (int i = 0; i < 8; i++) frm[i] = 0;
      en = '0;
      refresh();
      for (int i = 0; i < 8; i++) begin
         lens[i] = 16'd64;
         wts[i]  = 8'd1;
      end
   endtask

   task automatic pulse_clear();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic get_grant(output int q, input bit clr_with_done);
      int waited = 0;
      q = -1;
      while (!grant_o && waited < 300) begin
         @(negedge clk);
         waited++;
      end
      if (!grant_o) begin
         chk(1'b0, "R3 grant timeout", waited, 300);
      end else begin
         q = int'(sel_q_o);
         frm[q]--;
         refresh();
         fd  = 1'b1;
         clr = clr_with_done;
         @(negedge clk);
         fd  = 1'b0;
         clr = 1'b0;
      end
   endtask

   task automatic expect_seq(input string req, input int n);
      int q;
      for (int i = 0; i < n; i++) begin
         get_grant(q, 1'b0);
         chk(q == exp_q[i], req, q, exp_q[i]);
      end
   endtask

   // R1: reset state, no grant with nothing eligible
   task automatic t_reset();
      chk(grant_o == 1'b0, "R1 grant after reset", grant_o, 0);
      chk(sel_q_o == 3'd0, "R1 sel after reset", sel_q_o, 0);
      frm[3] = 4;
      refresh();
      repeat (10) begin
         @(negedge clk);
         if (grant_o) chk(1'b0, "R1 grant while nothing enabled", 1, 0);
      end
      chk(grant_o == 1'b0, "R1 idle stays quiet", grant_o, 0);
      frm[3] = 0;
      refresh();
   endtask

   // R2, R3, R10: strict priority
   task automatic t_priority();
      int q;
      idle_all();
      mode = 2'b00;
      en = 8'b1111_1101;
      frm[1] = 3;
      frm[2] = 2;
      frm[5] = 1;
      refresh();
      get_grant(q, 1'b0);
      chk(q == 2, "R2 lowest eligible first", q, 2);
      frm[0] = 1;
      refresh();
      chk(grant_o == 1'b0, "R3 no grant one cycle after done", grant_o, 0);
      @(negedge clk);
      chk(grant_o == 1'b1, "R3 grant two cycles after done", grant_o, 1);
      get_grant(q, 1'b0);
      chk(q == 0, "R2 re-evaluated at frame boundary", q, 0);
      get_grant(q, 1'b0);
      chk(q == 2, "R2 next lowest", q, 2);
      get_grant(q, 1'b0);
      chk(q == 5, "R2 last eligible", q, 5);
      repeat (20) begin
         @(negedge clk);
         if (grant_o) chk(1'b0, "R10 disabled queue granted", sel_q_o, 99);
      end
      chk(grant_o == 1'b0, "R10 disabled queue with frames stays idle", grant_o, 0);
   endtask

   // R4, R5: weights, rounding, rotation and skipping
   task automatic t_weighted();
      idle_all();
      mode = 2'b10;
      en = 8'b0000_0110;
      frm[1] = 20;
      frm[2] = 20;
      lens[1] = 16'd65;
      wts[1] = 8'd3;
      wts[2] = 8'd1;
      refresh();
      @(negedge clk);
      pulse_clear();
      exp_q = '{1, 1, 2, 1, 2, 1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0};
      expect_seq("R4 R5 weighted rotation with rounded-up length", 8);
   endtask

   // R6: queue 0 turn before every slot
   task automatic t_expedite();
      idle_all();
      en = 8'b0000_0111;
      frm[0] = 10;
      frm[1] = 20;
      frm[2] = 20;
      refresh();
      pulse_clear();
      exp_q = '{0, 1, 0, 2, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0};
      expect_seq("R6 expedited queue 0 turns", 11);
   endtask

   // R7: queue empties during its turn
   task automatic t_drain();
      int q;
      idle_all();
      en = 8'b0000_0110;
      frm[1] = 1;
      frm[2] = 20;
      wts[1] = 8'd3;
      refresh();
      pulse_clear();
      get_grant(q, 1'b0);
      chk(q == 1, "R7 first turn", q, 1);
      get_grant(q, 1'b0);
      chk(q == 2, "R7 turn passes on after empty", q, 2);
      frm[1] = 5;
      refresh();
      exp_q = '{1, 1, 1, 2, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      expect_seq("R7 credit zeroed on empty", 6);
   endtask

   // R8: clear coinciding with frame completion
   task automatic t_clear_with_done();
      int q;
      idle_all();
      en = 8'b0000_0110;
      frm[1] = 20;
      frm[2] = 20;
      wts[1] = 8'd4;
      refresh();
      pulse_clear();
      get_grant(q, 1'b1);
      chk(q == 1, "R8 grant before clear", q, 1);
      exp_q = '{1, 1, 1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      expect_seq("R8 rotation restarts after clear with done", 5);
   endtask

   // R9, R3: mode change while a frame is outstanding
   task automatic t_mode_change();
      int q;
      int waited = 0;
      idle_all();
      en = 8'b0000_0110;
      frm[1] = 20;
      frm[2] = 20;
      wts[1] = 8'd4;
      refresh();
      pulse_clear();
      while (!grant_o && waited < 300) begin
         @(negedge clk);
         waited++;
      end
      chk(grant_o && sel_q_o == 3'd1, "R9 first weighted grant", sel_q_o, 1);
      frm[1]--;
      refresh();
      mode = 2'b00;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!grant_o && sel_q_o == 3'd1, "R3 held while frame outstanding", grant_o, 0);
      end
      fd = 1'b1;
      @(negedge clk);
      fd = 1'b0;
      get_grant(q, 1'b0);
      chk(q == 1, "R9 priority after boundary", q, 1);
      wts[1] = 8'd2;
      mode = 2'b10;
      exp_q = '{1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      expect_seq("R9 mode change clears credits", 3);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) frm[i] = 0;
      idle_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_priority();
      t_weighted();
      t_expedite();
      t_drain();
      t_clear_with_done();
      t_mode_change();
      repeat (5) @(negedge clk);
      summary();
      $finish;
   end

endmodule